// File: doc/BRIEF.md
# Parallel-Switch Layer Allocator

This block decides which of several slower internal switching layers an arriving cell is sent through. Each cell arrives with the number of the input port it came in on and a bitmap of its destination outputs. The allocator keeps a timed record for every input and for every output. The record shows which layers that port started a cell on recently. A layer is eligible for a cell only if it is free on the cell's input and free on every destination output. Among the eligible layers the lowest-numbered one is granted. Every granted cell gets a sequence stamp, and cells must later be released in stamp order.

Time slots are marked by a `slot_tick` strobe, so several cells (one from each input, for example) can be allocated within one slot. When a port starts a cell on a layer, that layer is blocked for that port for the rest of the current slot and for the next `WINDOW-1` slots. `WINDOW` plays the role of ceil(layers / speedup). A cell whose constraints leave no layer is returned with an error flag. Nothing is recorded for such a cell and its stamp is not consumed.

Cells enter on a valid/ready stream and results leave on a valid/ready stream with one register stage. The block accepts a cell when the output register is empty or is being drained in the same cycle, so `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new cell is taken. A transfer happens on any rising clock edge where valid and ready are both high.

Top module: `pps_layer_alloc`

## Requirements
- R1: An accepted cell is granted the lowest-numbered layer that is free on its input port and free on all of its destination outputs. `out_layer` carries the layer as a binary index.
- R2: After an input starts a cell on layer L, L is not granted to another cell from that input until `WINDOW` slot ticks have passed. If the start and a tick fall in the same cycle, `WINDOW-1` further ticks are needed.
- R3: The same window rule holds for every output that receives a cell on layer L.
- R4: For a multicast cell, bit j of `in_dest` selects output j. The granted layer is free on the input and on every selected output, and it is recorded against all of them.
- R5: The result has `out_err`=1 and `out_layer`=0 in two cases: no layer is free on all constraints, or `in_dest` is all zero. Such a cell records no layer use and does not advance the stamp.
- R6: Successful allocations receive stamps 0, 1, 2, … in acceptance order. An errored result carries the stamp the next successful cell would get.
- R7: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. A held result keeps `out_layer`, `out_stamp` and `out_err` unchanged.
- R8: Synchronous reset clears every input and output record, empties the output register and restarts stamps at 0.
- R9: Layer windows age only on cycles with `slot_tick` high. Cycles without a tick leave every blocked layer blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_tick | input | 1 | Marks the last cycle of a time slot |
| in_valid | input | 1 | Arriving cell present |
| in_ready | output | 1 | Cell accepted when high together with in_valid |
| in_port | input | IN_W | Input port number of the cell |
| in_dest | input | NUM_OUT | Destination bitmap, bit j = output j |
| out_valid | output | 1 | Allocation result present |
| out_ready | input | 1 | Consumer takes the result |
| out_layer | output | LYR_W | Granted layer index |
| out_stamp | output | STAMP_W | Sequence stamp |
| out_err | output | 1 | No layer could be granted |

## Verification
The hardest state to reach from the ports is the case where the constraints together cover every layer, so that the error path runs. With one cell per slot the windows never cover all layers. The stimulus therefore sends several cells from one input to one output inside a single slot, with no tick, until every layer is taken. It then sends one more cell, and after a tick a cell from an input whose layers are all still blocked. Mixed unicast and multicast cells across ticks then check that blocked layers come free after exactly the window, and that stamps skip none and repeat none across errored cells.

// File: rtl/pps_alloc_pkg.sv
package pps_alloc_pkg;

  // Next value of a per-port, per-layer busy counter.
  // A start loads the full window. A start in the tick cycle has already
  // used up one slot of the window. Otherwise each tick counts down to zero.
  function automatic int busy_next(input int cur, input logic start,
                                   input logic tick, input int window);
    if (start) begin
      return tick ? (window - 1) : window;
    end
    if (tick && (cur != 0)) begin
      return cur - 1;
    end
    return cur;
  endfunction

endpackage

// File: rtl/pps_busy_table.sv
module pps_busy_table #(
  parameter int NUM_ENT    = 4,
  parameter int NUM_LAYERS = 4,
  parameter int WINDOW     = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 slot_tick,
  input  logic                                 use_en,
  input  logic [NUM_ENT-1:0]                   use_ent,
  input  logic [NUM_LAYERS-1:0]                use_lyr,
  output logic [NUM_ENT-1:0][NUM_LAYERS-1:0]   free_map
);
  import pps_alloc_pkg::*;

  localparam int CNT_W = $clog2(WINDOW + 1);

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_lyr
      logic [CNT_W-1:0] busy_q;
      logic             start;

      assign start = use_en & use_ent[e] & use_lyr[l];

      always_ff @(posedge clk) begin
        if (rst) begin
          busy_q <= '0;
        end else begin
          busy_q <= CNT_W'(busy_next(int'(busy_q), start, slot_tick, WINDOW));
        end
      end

      assign free_map[e][l] = (busy_q == '0);
    end
  end

endmodule

// File: rtl/pps_avail_merge.sv
module pps_avail_merge #(
  parameter int NUM_IN     = 4,
  parameter int NUM_OUT    = 4,
  parameter int NUM_LAYERS = 4,
  localparam int IN_W      = $clog2(NUM_IN)
) (
  input  logic [NUM_IN-1:0][NUM_LAYERS-1:0]  in_free,
  input  logic [NUM_OUT-1:0][NUM_LAYERS-1:0] out_free,
  input  logic [IN_W-1:0]                    port,
  input  logic [NUM_OUT-1:0]                 dest,
  output logic [NUM_LAYERS-1:0]              cand
);

  always_comb begin
    cand = in_free[port];
    for (int j = 0; j < NUM_OUT; j++) begin
      if (dest[j]) begin
        cand = cand & out_free[j];
      end
    end
  end

endmodule

// File: rtl/pps_lowest_pick.sv
module pps_lowest_pick #(
  parameter int NUM_LAYERS = 4,
  localparam int LYR_W     = $clog2(NUM_LAYERS)
) (
  input  logic [NUM_LAYERS-1:0] cand,
  output logic                  found,
  output logic [LYR_W-1:0]      idx,
  output logic [NUM_LAYERS-1:0] onehot
);

  always_comb begin
    found  = |cand;
    idx    = '0;
    onehot = '0;
    for (int l = NUM_LAYERS - 1; l >= 0; l--) begin
      if (cand[l]) begin
        idx    = LYR_W'(l);
        onehot = NUM_LAYERS'(1) << l;
      end
    end
  end

endmodule

// File: rtl/pps_layer_alloc.sv
module pps_layer_alloc #(
  parameter int NUM_IN     = 4,
  parameter int NUM_OUT    = 4,
  parameter int NUM_LAYERS = 4,
  parameter int WINDOW     = 2,
  parameter int STAMP_W    = 16,
  localparam int IN_W      = $clog2(NUM_IN),
  localparam int LYR_W     = $clog2(NUM_LAYERS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_tick,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IN_W-1:0]    in_port,
  input  logic [NUM_OUT-1:0] in_dest,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LYR_W-1:0]   out_layer,
  output logic [STAMP_W-1:0] out_stamp,
  output logic               out_err
);

  logic [NUM_IN-1:0][NUM_LAYERS-1:0]  in_free;
  logic [NUM_OUT-1:0][NUM_LAYERS-1:0] out_free;
  logic [NUM_LAYERS-1:0]              cand;
  logic [NUM_LAYERS-1:0]              pick_1h;
  logic [LYR_W-1:0]                   pick_idx;
  logic                               pick_ok;
  logic                               accept;
  logic                               grant;
  logic [NUM_IN-1:0]                  in_sel;
  logic [STAMP_W-1:0]                 stamp_q;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign grant    = accept && pick_ok && (|in_dest);
  assign in_sel   = NUM_IN'(1) << in_port;

  pps_busy_table #(
    .NUM_ENT(NUM_IN), .NUM_LAYERS(NUM_LAYERS), .WINDOW(WINDOW)
  ) u_in_tbl (
    .clk(clk), .rst(rst), .slot_tick(slot_tick),
    .use_en(grant), .use_ent(in_sel), .use_lyr(pick_1h),
    .free_map(in_free)
  );

  pps_busy_table #(
    .NUM_ENT(NUM_OUT), .NUM_LAYERS(NUM_LAYERS), .WINDOW(WINDOW)
  ) u_out_tbl (
    .clk(clk), .rst(rst), .slot_tick(slot_tick),
    .use_en(grant), .use_ent(in_dest), .use_lyr(pick_1h),
    .free_map(out_free)
  );

  pps_avail_merge #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_LAYERS(NUM_LAYERS)
  ) u_merge (
    .in_free(in_free), .out_free(out_free),
    .port(in_port), .dest(in_dest), .cand(cand)
  );

  pps_lowest_pick #(.NUM_LAYERS(NUM_LAYERS)) u_pick (
    .cand(cand), .found(pick_ok), .idx(pick_idx), .onehot(pick_1h)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q <= '0;
    end else if (grant) begin
      stamp_q <= stamp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_layer <= '0;
      out_stamp <= '0;
      out_err   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_layer <= grant ? pick_idx : '0;
      out_stamp <= stamp_q;
      out_err   <= !grant;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pps_layer_alloc_chk.sv
module pps_layer_alloc_chk #(
  parameter int NUM_LAYERS = 4,
  parameter int STAMP_W    = 16,
  localparam int LYR_W     = $clog2(NUM_LAYERS)
) (
  input logic               clk,
  input logic               rst,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LYR_W-1:0]   out_layer,
  input logic [STAMP_W-1:0] out_stamp,
  input logic               out_err
);

  logic [STAMP_W-1:0] last_q;
  logic               seen_q;
  logic [STAMP_W-1:0] exp_stamp;

  assign exp_stamp = seen_q ? (last_q + 1'b1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      seen_q <= 1'b0;
    end else if (out_valid && out_ready && !out_err) begin
      last_q <= out_stamp;
      seen_q <= 1'b1;
    end
  end

  // R6: stamps of granted cells run without gaps
  a_r6_stamp_seq: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_err) |-> (out_stamp == exp_stamp));

  // R5: errored result uses layer 0 and does not consume a stamp
  a_r5_err_no_stamp: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_err) |-> (out_stamp == exp_stamp && out_layer == '0));

  // R7: stalled result is held
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_layer)
                                   && $stable(out_stamp) && $stable(out_err)));

  // R7: no intake while stalled
  a_r7_block: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: reset empties the output register
  a_r8_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);

endmodule

bind pps_layer_alloc pps_layer_alloc_chk #(
  .NUM_LAYERS(NUM_LAYERS), .STAMP_W(STAMP_W)
) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_layer(out_layer), .out_stamp(out_stamp),
  .out_err(out_err)
);

// File: tb/pps_layer_alloc_tb_top.sv
module pps_layer_alloc_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slot_tick = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_port = '0;
  logic [3:0]  in_dest = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_layer;
  logic [15:0] out_stamp;
  logic        out_err;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pps_layer_alloc dut_i (
    .clk(clk), .rst(rst), .slot_tick(slot_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_port(in_port),
    .in_dest(in_dest), .out_valid(out_valid), .out_ready(out_ready),
    .out_layer(out_layer), .out_stamp(out_stamp), .out_err(out_err)
  );

  // {tick, valid, port, dest, layer, err, stamp}; defaults: 4 layers, window 2
  localparam int NV = 15;
  localparam logic [18:0] VECS [NV] = '{
    {1'b0, 1'b1, 2'd0, 4'b0001, 2'd0, 1'b0, 8'd0},
    {1'b0, 1'b1, 2'd0, 4'b0001, 2'd1, 1'b0, 8'd1},
    {1'b0, 1'b1, 2'd0, 4'b0001, 2'd2, 1'b0, 8'd2},
    {1'b0, 1'b1, 2'd0, 4'b0001, 2'd3, 1'b0, 8'd3},
    {1'b0, 1'b1, 2'd0, 4'b0001, 2'd0, 1'b1, 8'd4},
    {1'b1, 1'b1, 2'd1, 4'b0010, 2'd0, 1'b0, 8'd4},
    {1'b0, 1'b1, 2'd0, 4'b0100, 2'd0, 1'b1, 8'd5},
    {1'b0, 1'b1, 2'd2, 4'b0001, 2'd0, 1'b1, 8'd5},
    {1'b0, 1'b1, 2'd2, 4'b0010, 2'd1, 1'b0, 8'd5},
    {1'b1, 1'b1, 2'd1, 4'b0110, 2'd2, 1'b0, 8'd6},
    {1'b0, 1'b1, 2'd3, 4'b0011, 2'd0, 1'b0, 8'd7},
    {1'b0, 1'b1, 2'd2, 4'b1010, 2'd3, 1'b0, 8'd8},
    {1'b0, 1'b1, 2'd0, 4'b0000, 2'd0, 1'b1, 8'd9},
    {1'b1, 1'b0, 2'd0, 4'b0000, 2'd0, 1'b0, 8'd0},
    {1'b0, 1'b1, 2'd3, 4'b0001, 2'd1, 1'b0, 8'd9}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 2, 3: return "R1/R2/R3";
      4, 12:      return "R5";
      5, 13, 14:  return "R9";
      6:          return "R2";
      7, 8:       return "R3";
      default:    return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "out_valid after reset", int'(out_valid), 0);
    chk("R8", "in_ready after reset", int'(in_ready), 1);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VECS[i];
      @(negedge clk);
      slot_tick = v[18];
      in_valid  = v[17];
      in_port   = v[16:15];
      in_dest   = v[14:11];
      @(posedge clk);
      #1;
      if (v[17]) begin
        chk(tag_of(i), "out_valid", int'(out_valid), 1);
        chk(tag_of(i), "out_err", int'(out_err), int'(v[8]));
        chk(tag_of(i), "out_layer", int'(out_layer), int'(v[10:9]));
        chk("R6", "out_stamp", int'(out_stamp), int'(v[7:0]));
      end else begin
        chk(tag_of(i), "idle out_valid", int'(out_valid), 0);
      end
    end

    // R8: reset clears records and stamps
    @(negedge clk);
    slot_tick = 1'b0;
    in_valid  = 1'b0;
    rst       = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8", "out_valid in reset", int'(out_valid), 0);
    rst      = 1'b0;
    in_valid = 1'b1;
    in_port  = 2'd0;
    in_dest  = 4'b0001;
    @(posedge clk);
    #1;
    chk("R8", "layer after reset", int'(out_layer), 0);
    chk("R8", "stamp after reset", int'(out_stamp), 0);

    // R7: stall holds result and blocks intake
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
    @(posedge clk);
    #1;
    chk("R7", "held valid", int'(out_valid), 1);
    chk("R7", "held stamp", int'(out_stamp), 0);
    chk("R7", "in_ready while stalled", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    chk("R7", "no intake while stalled: layer", int'(out_layer), 0);
    chk("R7", "no intake while stalled: stamp", int'(out_stamp), 0);
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    chk("R7", "accepted after release: stamp", int'(out_stamp), 1);
    chk("R2", "same slot reuse blocked", int'(out_layer), 1);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R7", "drained", int'(out_valid), 0);

    summary();
    $finish;
  end

endmodule